// File: doc/BRIEF.md
# Transmit Backplane Sync Controller

This block produces the transmit frame and multiframe timing for a T1 framer and handles the two sync pins on the backplane. A configuration word sets three things. The first is whether the frame sync pin carries frame or multiframe boundaries. The second is a direction bit that, together with the transmit line clock source field, decides whether the block drives the sync pins or follows them. The third is whether the CRC-6 positions are filled by the framer or taken unchanged from the serial data input.

When the block drives, a free-running bit counter and frame counter make one-cycle boundary pulses, and the same pulses go out on the pins with their output enables high. When the block follows, a rising edge seen on a sync pin realigns the counters, and the framer keeps getting pulses in the new phase. In H.100 mode the frame is 1024 cycles long, and the direction bit instead chooses where the two-cycle sync pulse sits. A new direction bit takes effect only when the frame counter wraps, so the pin enables never change partway through a frame.

Top module: `tx_sync_ctrl`

## Requirements
- R1: After reset the configuration fields are all 0 and both counters are 0. Until the first clock edge, frame_pulse_o, mframe_pulse_o, sync_pin_oe_o and msync_pin_oe_o are 1 and crc_pass_o is 0, with clk_src_i=0 and bp_mode_i=0.
- R2: frame_pulse_o is high one cycle in every 193 in T1 modes (bp_mode_i 0 or 1) and one in every 1024 in H.100 mode (bp_mode_i=2). mframe_pulse_o is high on every 24th frame pulse, and only together with a frame pulse.
- R3: The active direction bit and clk_src_i set whether the block drives. With direction 0 the block drives unless clk_src_i equals 1. With direction 1 it drives only when clk_src_i equals 1. sync_pin_oe_o shows this drive state.
- R4: A new direction bit, written with cfg_wr_i, takes effect in the cycle in which frame_pulse_o next rises. A change of clk_src_i takes effect at once.
- R5: When driving in T1 modes, sync_pin_o equals the frame pulse if the superframe select (cfg_sf_sel_i) is 0, and the multiframe pulse if it is 1.
- R6: msync_pin_oe_o is 1 only when driving in basic mode (bp_mode_i=0) with superframe select 0. msync_pin_o carries the multiframe pulse.
- R7: In H.100 mode, direction 0 puts sync_pin_o high on counts 1023 and 0. Direction 1 puts it high on counts 0 and 1.
- R8: When not driving, a rising edge on sync_pin_i realigns the frame counter. In T1 mode, if sync_pin_i was first high in cycle N, frame_pulse_o is high in cycle N+193 and low in cycle N+192.
- R9: When not driving, the multiframe counter is realigned so that the sync pulse frame becomes frame 0, with mframe_pulse_o high in cycle N+24*193. This happens on a sync_pin_i edge when superframe select is 1, and on an msync_pin_i edge in basic mode when superframe select is 0.
- R10: crc_pass_o is 1 (CRC-6 pass-through) only when the CRC source bit (cfg_crc_src_i) is 1 and bp_mode_i is 0; otherwise it is 0 (internal CRC-6).
- R11: In bp_mode_i=1 the msync pin is never driven, and an edge on msync_pin_i has no effect on frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Write strobe for the configuration fields |
| cfg_sf_sel_i | input | 1 | Superframe select: 0 frame sync, 1 multiframe sync |
| cfg_dir_i | input | 1 | Direction bit, applied at the next frame boundary |
| cfg_crc_src_i | input | 1 | CRC-6 source: 0 internal, 1 pass-through |
| clk_src_i | input | 2 | Transmit line clock source field |
| bp_mode_i | input | 2 | 0 basic T1, 1 T1 with clock on msync pin, 2 H.100 |
| sync_pin_i | input | 1 | Sampled level of the frame sync pin |
| msync_pin_i | input | 1 | Sampled level of the multiframe sync pin |
| sync_pin_o | output | 1 | Value driven on the frame sync pin |
| sync_pin_oe_o | output | 1 | Output enable for the frame sync pin |
| msync_pin_o | output | 1 | Value driven on the multiframe sync pin |
| msync_pin_oe_o | output | 1 | Output enable for the multiframe sync pin |
| frame_pulse_o | output | 1 | One-cycle frame boundary pulse |
| mframe_pulse_o | output | 1 | One-cycle multiframe boundary pulse |
| crc_pass_o | output | 1 | CRC-6 pass-through select |

## Verification
The output-enable property assumes that clk_src_i is the only input that can move the pin enables between frame boundaries. The bench therefore changes clk_src_i only where an enable change is expected, and otherwise sends direction changes through the write strobe. The realignment checks assume the sync pins toggle only while the block is not driving them, so the bench keeps sync_pin_i and msync_pin_i low except in the input-mode tests. The sync pulses there are one cycle wide and well away from any mode or direction change.

// File: rtl/tx_sync_pkg.sv
package tx_sync_pkg;
  typedef enum logic [1:0] {
    BP_T1_BASIC = 2'd0,
    BP_T1_CLKIN = 2'd1,
    BP_H100     = 2'd2,
    BP_RSVD     = 2'd3
  } bp_mode_e;

  typedef struct packed {
    logic sf_sel;
    logic dir;
    logic crc_src;
  } sync_cfg_t;
endpackage

// File: rtl/tx_sync_cfg.sv
module tx_sync_cfg
  import tx_sync_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  sync_cfg_t wr_cfg_i,
  input  logic      frame_end_i,
  output sync_cfg_t cfg_o
);
  sync_cfg_t cfg_q;
  logic      dir_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      dir_act_q <= 1'b0;
    end else begin
      if (wr_i) cfg_q <= wr_cfg_i;
      // direction only moves where the counter wraps
      if (frame_end_i) dir_act_q <= cfg_q.dir;
    end
  end

  always_comb begin
    cfg_o     = cfg_q;
    cfg_o.dir = dir_act_q;
  end
endmodule

// File: rtl/tx_sync_edge.sv
module tx_sync_edge #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], pin_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/tx_sync_timer.sv
module tx_sync_timer #(
  parameter int unsigned T1_LEN   = 193,
  parameter int unsigned H100_LEN = 1024,
  parameter int unsigned MF_LEN   = 24,
  localparam int unsigned CW = $clog2(H100_LEN > T1_LEN ? H100_LEN : T1_LEN),
  localparam int unsigned FW = $clog2(MF_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          h100_i,
  input  logic          realign_frm_i,
  input  logic          realign_mf_i,
  input  logic [CW-1:0] load_i,
  output logic [CW-1:0] bit_cnt_o,
  output logic [FW-1:0] frm_cnt_o,
  output logic          frame_end_o
);
  localparam logic [CW-1:0] T1_LAST   = CW'(T1_LEN - 1);
  localparam logic [CW-1:0] H100_LAST = CW'(H100_LEN - 1);
  localparam logic [FW-1:0] MF_LAST   = FW'(MF_LEN - 1);

  logic [CW-1:0] bit_q, last;
  logic [FW-1:0] frm_q;
  logic          wrap;

  assign last        = h100_i ? H100_LAST : T1_LAST;
  assign wrap        = (bit_q >= last);
  assign frame_end_o = wrap & ~realign_frm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      frm_q <= '0;
    end else if (realign_frm_i) begin
      bit_q <= load_i;
      if (realign_mf_i) frm_q <= '0;
    end else if (wrap) begin
      bit_q <= '0;
      frm_q <= (frm_q >= MF_LAST) ? '0 : frm_q + 1'b1;
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign bit_cnt_o = bit_q;
  assign frm_cnt_o = frm_q;
endmodule

// File: rtl/tx_sync_ctrl.sv
module tx_sync_ctrl
  import tx_sync_pkg::*;
#(
  parameter int unsigned T1_LEN        = 193,
  parameter int unsigned H100_LEN      = 1024,
  parameter int unsigned MF_LEN        = 24,
  parameter int unsigned SAMPLE_STAGES = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic       cfg_sf_sel_i,
  input  logic       cfg_dir_i,
  input  logic       cfg_crc_src_i,
  input  logic [1:0] clk_src_i,
  input  logic [1:0] bp_mode_i,
  input  logic       sync_pin_i,
  input  logic       msync_pin_i,
  output logic       sync_pin_o,
  output logic       sync_pin_oe_o,
  output logic       msync_pin_o,
  output logic       msync_pin_oe_o,
  output logic       frame_pulse_o,
  output logic       mframe_pulse_o,
  output logic       crc_pass_o
);
  localparam int unsigned CW = $clog2(H100_LEN > T1_LEN ? H100_LEN : T1_LEN);
  localparam int unsigned FW = $clog2(MF_LEN);
  localparam logic [CW-1:0] H100_LAST = CW'(H100_LEN - 1);
  // counter value after the edge detector's delay, per pulse placement
  localparam logic [CW-1:0] LOAD_AT_ZERO = CW'(SAMPLE_STAGES + 1);
  localparam logic [CW-1:0] LOAD_AT_LAST = CW'(SAMPLE_STAGES);

  bp_mode_e      mode;
  sync_cfg_t     wr_cfg, cfg;
  logic          frame_end, rise_s, rise_m;
  logic          drive, basic, h100;
  logic          realign_frm, realign_mf;
  logic [CW-1:0] bit_cnt, load;
  logic [FW-1:0] frm_cnt;
  logic          h100_pulse;

  assign mode   = bp_mode_e'(bp_mode_i);
  assign basic  = (mode == BP_T1_BASIC);
  assign h100   = (mode == BP_H100);
  assign wr_cfg = '{sf_sel: cfg_sf_sel_i, dir: cfg_dir_i, crc_src: cfg_crc_src_i};

  tx_sync_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (cfg_wr_i),
    .wr_cfg_i    (wr_cfg),
    .frame_end_i (frame_end),
    .cfg_o       (cfg)
  );

  tx_sync_edge #(.STAGES(SAMPLE_STAGES)) u_edge_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (sync_pin_i),
    .rise_o (rise_s)
  );

  tx_sync_edge #(.STAGES(SAMPLE_STAGES)) u_edge_msync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (msync_pin_i),
    .rise_o (rise_m)
  );

  // dir=0: drive unless clock source is 1; dir=1: the inverse
  assign drive = cfg.dir ? (clk_src_i == 2'd1) : (clk_src_i != 2'd1);

  assign realign_mf  = ~drive & ((rise_s & cfg.sf_sel & ~h100) |
                                 (rise_m & basic & ~cfg.sf_sel));
  assign realign_frm = ~drive & (rise_s | realign_mf);
  assign load        = (h100 & ~cfg.dir) ? LOAD_AT_LAST : LOAD_AT_ZERO;

  tx_sync_timer #(
    .T1_LEN   (T1_LEN),
    .H100_LEN (H100_LEN),
    .MF_LEN   (MF_LEN)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .h100_i        (h100),
    .realign_frm_i (realign_frm),
    .realign_mf_i  (realign_mf),
    .load_i        (load),
    .bit_cnt_o     (bit_cnt),
    .frm_cnt_o     (frm_cnt),
    .frame_end_o   (frame_end)
  );

  assign frame_pulse_o  = (bit_cnt == '0);
  assign mframe_pulse_o = frame_pulse_o & (frm_cnt == '0);

  assign h100_pulse = cfg.dir ? (bit_cnt <= CW'(1))
                              : ((bit_cnt == H100_LAST) | (bit_cnt == '0));

  always_comb begin
    if (h100)             sync_pin_o = h100_pulse;
    else if (cfg.sf_sel)  sync_pin_o = mframe_pulse_o;
    else                  sync_pin_o = frame_pulse_o;
  end

  assign sync_pin_oe_o  = drive;
  assign msync_pin_o    = mframe_pulse_o;
  assign msync_pin_oe_o = drive & basic & ~cfg.sf_sel;
  assign crc_pass_o     = cfg.crc_src & basic;
endmodule

// File: rtl/tx_sync_ctrl_chk.sv
module tx_sync_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] clk_src_i,
  input logic [1:0] bp_mode_i,
  input logic       sync_pin_o,
  input logic       sync_pin_oe_o,
  input logic       msync_pin_oe_o,
  input logic       frame_pulse_o,
  input logic       mframe_pulse_o,
  input logic       crc_pass_o
);
  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_o |=> !frame_pulse_o); // R2
  AST_MF_WITH_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mframe_pulse_o |-> frame_pulse_o); // R2
  AST_OE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sync_pin_oe_o != $past(sync_pin_oe_o)) && (clk_src_i == $past(clk_src_i)))
      |-> frame_pulse_o); // R4
  AST_T1_SYNC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_pin_oe_o && bp_mode_i != 2'd2 && sync_pin_o) |-> frame_pulse_o); // R5
  AST_MSYNC_OE_SCOPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msync_pin_oe_o |-> (sync_pin_oe_o && bp_mode_i == 2'd0)); // R6
  AST_CRC_BASIC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_pass_o |-> (bp_mode_i == 2'd0)); // R10
endmodule

bind tx_sync_ctrl tx_sync_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clk_src_i      (clk_src_i),
  .bp_mode_i      (bp_mode_i),
  .sync_pin_o     (sync_pin_o),
  .sync_pin_oe_o  (sync_pin_oe_o),
  .msync_pin_oe_o (msync_pin_oe_o),
  .frame_pulse_o  (frame_pulse_o),
  .mframe_pulse_o (mframe_pulse_o),
  .crc_pass_o     (crc_pass_o)
);

// File: tb/tx_sync_ctrl_test.sv
module tx_sync_ctrl_test;
  localparam int P  = 193;
  localparam int PH = 1024;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       cfg_wr = 1'b0, cfg_sf = 1'b0, cfg_dir = 1'b0, cfg_crc = 1'b0;
  logic [1:0] clk_src = 2'd0, bp_mode = 2'd0;
  logic       sync_in = 1'b0, msync_in = 1'b0;
  logic       sync_pin_o, sync_pin_oe_o, msync_pin_o, msync_pin_oe_o;
  logic       frame_pulse_o, mframe_pulse_o, crc_pass_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  tx_sync_ctrl uut (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .cfg_wr_i       (cfg_wr),
    .cfg_sf_sel_i   (cfg_sf),
    .cfg_dir_i      (cfg_dir),
    .cfg_crc_src_i  (cfg_crc),
    .clk_src_i      (clk_src),
    .bp_mode_i      (bp_mode),
    .sync_pin_i     (sync_in),
    .msync_pin_i    (msync_in),
    .sync_pin_o     (sync_pin_o),
    .sync_pin_oe_o  (sync_pin_oe_o),
    .msync_pin_o    (msync_pin_o),
    .msync_pin_oe_o (msync_pin_oe_o),
    .frame_pulse_o  (frame_pulse_o),
    .mframe_pulse_o (mframe_pulse_o),
    .crc_pass_o     (crc_pass_o)
  );

  // {dir, clk_src[1:0], mode[1:0], sf_sel, crc_src, exp_oe, exp_moe, exp_crc}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b1, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {1'b1, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {1'b0, 2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {1'b1, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(logic sf, logic d, logic c);
    cfg_wr = 1'b1; cfg_sf = sf; cfg_dir = d; cfg_crc = c;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_frame();
    @(negedge clk);
    while (!frame_pulse_o) @(negedge clk);
  endtask

  task automatic wait_mframe();
    @(negedge clk);
    while (!mframe_pulse_o) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    step(3);
    rst_ni = 1'b1;
    // R1 reset state, before the first edge after release
    chk("R1 frame_pulse", frame_pulse_o, 1);
    chk("R1 mframe_pulse", mframe_pulse_o, 1);
    chk("R1 sync_oe", sync_pin_oe_o, 1);
    chk("R1 msync_oe", msync_pin_oe_o, 1);
    chk("R1 crc_pass", crc_pass_o, 0);

    // R2 frame period in T1
    n = 0;
    do begin step(1); n++; end while (!frame_pulse_o);
    chk("R2 t1 period", n, P);

    // R2 multiframe length in frames
    wait_mframe();
    n = 0;
    do begin wait_frame(); n++; end while (!mframe_pulse_o);
    chk("R2 frames per mf", n, 24);

    // R5/R6 driving basic, sf_sel 0
    chk("R5 sync at mf", sync_pin_o, 1);
    chk("R6 msync at mf", msync_pin_o, 1);
    wait_frame();
    chk("R5 sync at frame", sync_pin_o, 1);
    chk("R6 msync off non-mf", msync_pin_o, 0);
    step(1);
    chk("R5 sync mid frame", sync_pin_o, 0);

    // R5 sf_sel 1: sync carries multiframe only
    wr_cfg(1'b1, 1'b0, 1'b0);
    wait_mframe();
    chk("R5 sf1 sync at mf", sync_pin_o, 1);
    wait_frame();
    chk("R5 sf1 sync at plain frame", sync_pin_o, 0);

    // R3 R6 R10 table
    for (int i = 0; i < 8; i++) begin
      clk_src = VEC[i][8:7];
      bp_mode = VEC[i][6:5];
      wr_cfg(VEC[i][4], VEC[i][9], VEC[i][3]);
      wait_frame();
      step(1);
      chk($sformatf("R3 vec%0d oe", i), sync_pin_oe_o, VEC[i][2]);
      chk($sformatf("R6 vec%0d msync_oe", i), msync_pin_oe_o, VEC[i][1]);
      chk($sformatf("R10 vec%0d crc_pass", i), crc_pass_o, VEC[i][0]);
    end

    // R4 clk_src immediate, direction deferred
    clk_src = 2'd1;
    step(1);
    chk("R4 clk_src immediate", sync_pin_oe_o, 0);
    wait_frame();
    step(1);
    wr_cfg(1'b0, 1'b1, 1'b0);
    step(1);
    chk("R4 dir deferred", sync_pin_oe_o, 0);
    wait_frame();
    chk("R4 dir at boundary", sync_pin_oe_o, 1);

    // R7 H.100 dir 0: drive with clk_src 0
    clk_src = 2'd0;
    bp_mode = 2'd2;
    wr_cfg(1'b0, 1'b0, 1'b0);
    wait_frame();
    wait_frame();
    chk("R7 d0 cnt0", sync_pin_o, 1);
    step(1);
    chk("R7 d0 cnt1", sync_pin_o, 0);
    step(1021);
    chk("R7 d0 cnt1022", sync_pin_o, 0);
    step(1);
    chk("R7 d0 cnt1023", sync_pin_o, 1);
    step(1);
    chk("R2 h100 period", frame_pulse_o, 1);

    // R7 H.100 dir 1: drive with clk_src 1
    clk_src = 2'd1;
    wr_cfg(1'b0, 1'b1, 1'b0);
    wait_frame();
    chk("R7 d1 oe", sync_pin_oe_o, 1);
    chk("R7 d1 cnt0", sync_pin_o, 1);
    step(1);
    chk("R7 d1 cnt1", sync_pin_o, 1);
    step(1);
    chk("R7 d1 cnt2", sync_pin_o, 0);
    step(PH - 3);
    chk("R7 d1 cnt1023", sync_pin_o, 0);

    // R8 input realign of frame, basic mode
    bp_mode = 2'd0;
    wr_cfg(1'b0, 1'b0, 1'b0);
    wait_frame();
    chk("R8 input mode", sync_pin_oe_o, 0);
    step(50);
    sync_in = 1'b1;
    step(1);
    sync_in = 1'b0;
    step(P - 2);
    chk("R8 before realigned pulse", frame_pulse_o, 0);
    step(1);
    chk("R8 realigned pulse", frame_pulse_o, 1);

    // R9 multiframe realign from msync pin, basic sf_sel 0
    step(70);
    sync_in = 1'b1; msync_in = 1'b1;
    step(1);
    sync_in = 1'b0; msync_in = 1'b0;
    step(P - 1);
    chk("R9 msync frame1 pulse", frame_pulse_o, 1);
    chk("R9 msync frame1 no mf", mframe_pulse_o, 0);
    step(23 * P);
    chk("R9 msync mf pulse", mframe_pulse_o, 1);

    // R9 multiframe realign from sync pin, sf_sel 1
    wr_cfg(1'b1, 1'b0, 1'b0);
    step(40);
    sync_in = 1'b1;
    step(1);
    sync_in = 1'b0;
    step(P - 1);
    chk("R9 sf1 frame1 no mf", mframe_pulse_o, 0);
    step(23 * P);
    chk("R9 sf1 mf pulse", mframe_pulse_o, 1);

    // R11 clock-in mode: msync never driven, its edge ignored
    bp_mode = 2'd1;
    wr_cfg(1'b0, 1'b0, 1'b0);
    step(30);
    chk("R11 msync oe", msync_pin_oe_o, 0);
    sync_in = 1'b1;
    step(1);
    sync_in = 1'b0;
    step(59);
    msync_in = 1'b1;
    step(1);
    msync_in = 1'b0;
    step(P - 61);
    chk("R11 frame phase kept", frame_pulse_o, 1);

    finish_run();
  end
endmodule